// File: doc/BRIEF.md
# Queued-Duty Pulse Width Modulator

This block drives one pulse-width-modulated output from a small register file. Software programs a period length and pushes duty values into a four-deep sample queue. The generator takes one queued value at the start of every PWM period, so a sequence of duty values plays out one per period without software having to write in step with the waveform. If the queue runs dry, the most recent value keeps playing.

A control register enables the output. It also sets a prescale divider, picks the counting source (halted, the bus clock, or an external reference strobe) and can invert the output. A self-clearing software-reset bit returns the block to its idle state and empties the queue. A status register shows how many queue entries are filled, together with a sticky flag that records writes dropped because the queue was full.

Top module: `fifo_pwm`

## Requirements
- R1: The register map is: address 0 control, 1 status, 2 sample, 3 period. Status bits [2:0] give the number of filled queue entries (0 to 4) and read 4 when the queue is full.
- R2: The counter restarts every period-register value + 2 counter ticks, counting 0 up to period+1. The output, before inversion, is high while the counter is below the current sample and low otherwise. A new period value takes effect at the next period start.
- R3: One queue entry becomes the current sample at every period start. A period starts when the output is enabled from the disabled state and each time the counter wraps. The status count drops by one at that point.
- R4: When the queue is empty at a period start, the previous sample is reused.
- R5: A sample write while the queue holds 4 entries is dropped, and status bit 7 is set. The bit stays set until software reset.
- R6: Control bits [15:4] hold the prescale divider N. The counter advances once every N selected source ticks, and N = 0 acts as 1.
- R7: Control bits [17:16] pick the source: 0 halts the counter, 1 and 2 count every bus clock, and 3 counts on cycles where ref_tick is high.
- R8: Control bit 18 inverts the output. This includes the level held while disabled, which becomes high.
- R9: Control bit 0 enables the output. Writing 0 to control disables it, holds the output at its inactive level and returns the counter to 0, so the next enable starts a fresh period.
- R10: Writing control with bit 3 set starts a software reset. Bit 3 then reads 1 for 4 cycles and then 0. During that time the queue is flushed, the overflow flag, control and period are cleared, and register writes are ignored.
- R11: After hardware reset every register reads 0 and pwm_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| ref_tick | input | 1 | External reference strobe, one bus cycle per tick |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions assume that ref_tick and the register strobe are synchronous to clk. They also assume that software does not change the period mid-period in a way it expects to act at once, because the counter bound is checked only against the latched period. The directed tests write registers only at negative edges, one write per cycle. Every waveform run starts from a disabled block, so that each period start and queue pop falls on a cycle the bench computes from the enable write.

// File: rtl/fifo_pwm.sv
module fifo_pwm #(
  parameter int DATA_W     = 16,
  parameter int PRE_W      = 12,
  parameter int DEPTH      = 4,
  parameter int SWR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        ref_tick,
  output logic        pwm_out
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CW    = DATA_W + 1;
  localparam int SW_W  = $clog2(SWR_CYCLES + 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_SAMP = 2'd2, A_PER = 2'd3;

  logic              en_q, inv_q, ovf_q;
  logic [1:0]        src_q;
  logic [PRE_W-1:0]  pre_q, pre_cnt;
  logic [DATA_W-1:0] per_q, per_act, cur_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  fcnt;
  logic [SW_W-1:0]   swr_cnt;

  logic busy, wr_ok, ctrl_wr, swr_req, ctrl_set, stop_req, start;
  logic src_tick, tick, wrap, load, pop, push, push_ok;
  logic [PRE_W-1:0] div_eff;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign busy     = swr_cnt != '0;
  assign wr_ok    = wr_en && !busy;
  assign ctrl_wr  = wr_ok && addr == A_CTRL;
  assign swr_req  = ctrl_wr && wdata[3];
  assign ctrl_set = ctrl_wr && !wdata[3];
  assign stop_req = ctrl_set && !wdata[0];
  assign start    = ctrl_set && wdata[0] && !en_q;
  assign div_eff  = (pre_q == '0) ? PRE_W'(1) : pre_q;

  always_comb begin
    case (src_q)
      2'd0:    src_tick = 1'b0;
      2'd3:    src_tick = ref_tick;
      default: src_tick = 1'b1;
    endcase
  end

  assign tick    = en_q && src_tick && (pre_cnt >= div_eff - PRE_W'(1));
  assign wrap    = tick && (cnt_q >= {1'b0, per_act} + CW'(1));
  assign load    = start || wrap;
  assign pop     = load && fcnt != '0;
  assign push    = wr_ok && addr == A_SAMP;
  assign push_ok = push && fcnt != CNT_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; inv_q <= 1'b0; src_q <= '0; pre_q <= '0;
      per_q <= '0; per_act <= '0; cnt_q <= '0; pre_cnt <= '0;
      cur_q <= '0; rd_ptr <= '0; wr_ptr <= '0; fcnt <= '0;
      ovf_q <= 1'b0; swr_cnt <= '0;
    end else if (busy) begin
      swr_cnt <= swr_cnt - SW_W'(1);
      en_q <= 1'b0; inv_q <= 1'b0; src_q <= '0; pre_q <= '0;
      per_q <= '0; per_act <= '0; cnt_q <= '0; pre_cnt <= '0;
      cur_q <= '0; rd_ptr <= '0; wr_ptr <= '0; fcnt <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (swr_req) begin
        swr_cnt <= SW_W'(SWR_CYCLES);
      end else if (ctrl_set) begin
        en_q  <= wdata[0];
        pre_q <= wdata[4 +: PRE_W];
        src_q <= wdata[17:16];
        inv_q <= wdata[18];
      end
      if (wr_ok && addr == A_PER) per_q <= wdata[DATA_W-1:0];

      if (start) begin
        cnt_q   <= '0;
        pre_cnt <= '0;
        per_act <= per_q;
      end else if (en_q && !stop_req) begin
        if (tick) begin
          pre_cnt <= '0;
          cnt_q   <= wrap ? '0 : cnt_q + CW'(1);
          if (wrap) per_act <= per_q;
        end else if (src_tick) begin
          pre_cnt <= pre_cnt + PRE_W'(1);
        end
      end else begin
        cnt_q   <= '0;
        pre_cnt <= '0;
      end

      if (pop) begin
        cur_q  <= mem[rd_ptr];
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
      if (push_ok)
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (push && !push_ok) ovf_q <= 1'b1;
      fcnt <= fcnt + CNT_W'(push_ok) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata[DATA_W-1:0];
  end

  assign pwm_out = en_q ? ((cnt_q < {1'b0, cur_q}) ^ inv_q) : inv_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[0]            = en_q;
        rdata[3]            = busy;
        rdata[4 +: PRE_W]   = pre_q;
        rdata[17:16]        = src_q;
        rdata[18]           = inv_q;
      end
      A_STAT: begin
        rdata[CNT_W-1:0] = fcnt;
        rdata[7]         = ovf_q;
      end
      A_SAMP:  rdata[DATA_W-1:0] = cur_q;
      default: rdata[DATA_W-1:0] = per_q;
    endcase
  end

  // R1
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CNT_W'(DEPTH));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> cnt_q <= {1'b0, per_act} + CW'(1));

  // R3
  fifo_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt < $past(fcnt)) && !$past(busy) |-> $past(load));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !busy |=> ovf_q);

  // R9
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> cnt_q == '0);

  // R10
  swr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> fcnt == '0 && !en_q);
endmodule

// File: tb/fifo_pwm_tb.sv
module fifo_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ref_tick = 1'b0;
  logic        pwm_out;
  int total = 0;
  int bad = 0;

  fifo_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ref_tick(ref_tick), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R11 register reset", int'(v), 0);
    end
    chk(pwm_out == 1'b0, "R11 output reset", int'(pwm_out), 0);
  endtask

  task automatic t_fifo();
    logic [31:0] v;
    wr(2, 10); wr(2, 10); wr(2, 10);
    rd(1, v);
    chk(v == 3, "R1 count 3", int'(v), 3);
    wr(2, 10);
    rd(1, v);
    chk(v == 4, "R1 full reads 4", int'(v), 4);
    wr(2, 11);
    rd(1, v);
    chk(v == 32'h84, "R5 drop and overflow flag", int'(v), 32'h84);
  endtask

  task automatic t_swr();
    logic [31:0] v;
    wr(3, 7);
    wr(0, 32'h8);
    rd(0, v);
    chk(v[3] == 1'b1, "R10 reset bit reads 1", int'(v[3]), 1);
    wr(3, 99);
    repeat (5) @(negedge clk);
    rd(0, v);
    chk(v == 0, "R10 reset bit self clears", int'(v), 0);
    rd(1, v);
    chk(v == 0, "R10 fifo flushed and flag cleared", int'(v), 0);
    rd(3, v);
    chk(v == 0, "R10 period cleared, write ignored", int'(v), 0);
  endtask

  task automatic t_wave();
    logic [31:0] v;
    int seq[3] = '{2, 5, 1};
    int errs = 0;
    wr(3, 4); wr(2, 2); wr(2, 5); wr(2, 1);
    wr(0, 32'h10011);
    rd(1, v);
    chk(v == 2, "R3 pop at enable", int'(v), 2);
    for (int k = 0; k < 30; k++) begin
      int j = k / 6;
      int s = seq[(j > 2) ? 2 : j];
      logic e = ((k % 6) < s);
      if (pwm_out !== e) errs++;
      if (k % 6 == 5) begin
        chk(errs == 0, (j > 2) ? "R4 reuse last sample" : "R2 R3 period shape", errs, 0);
        errs = 0;
      end
      @(negedge clk);
    end
    rd(1, v);
    chk(v == 0, "R3 queue drained", int'(v), 0);
  endtask

  task automatic t_disable();
    wr(0, 0);
    chk(pwm_out == 1'b0, "R9 disabled output low", int'(pwm_out), 0);
    wr(0, 32'h10011);
    chk(pwm_out == 1'b1, "R9 restart at count 0", int'(pwm_out), 1);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R9 count 1 above sample", int'(pwm_out), 0);
    wr(0, 0);
  endtask

  task automatic t_invert();
    wr(0, 32'h40000);
    chk(pwm_out == 1'b1, "R8 inverted idle level", int'(pwm_out), 1);
    wr(0, 32'h50011);
    chk(pwm_out == 1'b0, "R8 inverted active phase", int'(pwm_out), 0);
    @(negedge clk);
    chk(pwm_out == 1'b1, "R8 inverted inactive phase", int'(pwm_out), 1);
    wr(0, 0);
  endtask

  task automatic t_prescale();
    int errs = 0;
    wr(3, 2); wr(2, 3);
    wr(0, 32'h20031);
    for (int k = 0; k < 24; k++) begin
      logic e = (((k / 3) % 4) < 3);
      if (pwm_out !== e) errs++;
      if (k % 12 == 11) begin
        chk(errs == 0, "R6 R7 divide by 3 on source 2", errs, 0);
        errs = 0;
      end
      @(negedge clk);
    end
    wr(0, 0);
    wr(0, 32'h10001);
    for (int k = 0; k < 8; k++) begin
      logic e = ((k % 4) < 3);
      if (pwm_out !== e) errs++;
      @(negedge clk);
    end
    chk(errs == 0, "R6 divider 0 acts as 1", errs, 0);
    wr(0, 0);
  endtask

  task automatic t_ref();
    wr(0, 32'h00011);
    repeat (8) @(negedge clk);
    chk(pwm_out == 1'b1, "R7 source 0 halts", int'(pwm_out), 1);
    wr(0, 0);
    wr(0, 32'h30011);
    repeat (6) @(negedge clk);
    chk(pwm_out == 1'b1, "R7 no ref tick no advance", int'(pwm_out), 1);
    for (int p = 0; p < 2; p++) begin
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
      @(negedge clk);
    end
    chk(pwm_out == 1'b1, "R7 two ref ticks below sample", int'(pwm_out), 1);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R7 third ref tick reaches sample", int'(pwm_out), 0);
    wr(0, 0);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fifo();
    t_swr();
    t_wave();
    t_disable();
    t_invert();
    t_prescale();
    t_ref();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule